// File: doc/BRIEF.md
# Chained DMA Tag Sequencer

This block is the control engine of a DMA channel that follows a linked list of 64-bit tags held in memory. Once started at a tag address, it asks memory for the tag there and decodes it. The decode gives the tag's kind, its quadword count, its address word and its interrupt flag. The block then issues one transfer command, made of a byte address and a quadword count, to an external data mover. From the tag's kind it also works out where the next tag lives. A two-entry hardware stack of return addresses lets tags call into a sub-list and return from it.

The chain stops on an end-type tag, on a return with nothing on the stack, on a flagged tag when tag interrupts are enabled, or on an error. An error is a call that would overflow the stack, or an address that is not a multiple of 16 bytes. Stopping clears the running bit and gives a one-cycle done pulse. The upper half of the last tag's command word is reported on an output, and so is the stack occupancy.

Top module: `dma_chain_seq`

## Requirements
- R1: After synchronous reset, `running`, `fetch_req`, `xfer_req`, `tag_irq`, `chain_done`, `chain_err`, `stack_ptr` and `tag_hi` are all zero.
- R2: A `start_set` pulse while idle with a 16-byte-aligned `start_addr` sets `running`, clears the stack and makes the first tag request at `start_addr`. A `start_set` pulse while `running` is high has no effect on the sequence of requests.
- R3: Tag layout: bits 63:32 hold the address word, bit 31 the interrupt flag, bits 30:28 the kind, bits 27:26 a priority field and bits 15:0 the quadword count. After each tag is fetched, `tag_hi` shows that tag's bits 31:16.
- R4: Kinds cnt (1), next (2) and end (7) transfer from the tag's address plus 16. For cnt, the next tag is at the tag's address plus 16 plus 16 times the count. For next, the next tag is at the tag's address word. end stops the chain after its transfer.
- R5: Kinds ref (3), refs (4) and refe (0) transfer from the tag's address word. For ref and refs, the next tag is at the tag's address plus 16. refe stops the chain after its transfer.
- R6: call (5) transfers from the tag's address plus 16 and pushes the address just past its data. The next tag is then fetched at the tag's address word. ret (6) transfers from the tag's address plus 16, then continues at the most recently pushed address and removes it. When the stack is empty, ret stops the chain. `stack_ptr` gives the number of entries held, from 0 to 2.
- R7: A call met while the stack already holds two entries stops the chain with `chain_err` set. It issues no transfer and leaves the stack unchanged.
- R8: If a tag's kind uses the address word (refe, next, ref, refs, call) and any of bits 3:0 of that word is set, the chain stops with `chain_err` and issues no transfer. A misaligned `start_addr` sets `chain_err` and makes no tag request. Under cnt, a misaligned address word is ignored.
- R9: When a tag's interrupt flag is set and `tie` is high, the chain stops after that tag's transfer and `tag_irq` pulses together with `chain_done`. With `tie` low the flag has no effect.
- R10: A tag with a quadword count of zero issues no transfer command; sequencing proceeds as if its transfer had finished.
- R11: Every stop, whether normal or on error, drops `running` and gives a `chain_done` pulse one cycle long. `chain_err` holds until the next start.
- R12: At most one of `fetch_req` and `xfer_req` is high at a time. Each request holds its address (and count) steady until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | Pulse that starts a chain while idle |
| start_addr | input | 32 | Byte address of the first tag |
| tie | input | 1 | Enables the tag interrupt flag |
| fetch_req | output | 1 | Tag read request |
| fetch_addr | output | 32 | Byte address of the requested tag |
| fetch_ack | input | 1 | Tag data valid, ends the request |
| fetch_data | input | 64 | Tag returned by memory |
| xfer_req | output | 1 | Transfer command valid |
| xfer_addr | output | 32 | Byte address of the data block |
| xfer_qwc | output | 16 | Quadwords to move |
| xfer_done | input | 1 | Data mover finished the command |
| running | output | 1 | Channel active |
| tag_hi | output | 16 | Bits 31:16 of the last tag fetched |
| stack_ptr | output | 2 | Return-stack occupancy |
| tag_irq | output | 1 | One-cycle tag interrupt pulse |
| chain_done | output | 1 | One-cycle stop pulse |
| chain_err | output | 1 | Error flag, cleared by the next start |

## Verification
The assertions assume that `fetch_ack` and `xfer_done` are single-cycle pulses, each given only while its own request is high. They also assume that `tie` does not change during a chain. The bench's responder drives an acknowledge only in the cycle after it has seen the matching request. It drops that acknowledge at the next sample point and changes `tie` only between chains. A bench memory of 256 quadwords serves the tags. The sweep covers every tag kind with several counts, and its expected fetch and transfer addresses are computed from the tag arithmetic.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int ADDR_W   = 32;
  localparam int QWC_W    = 16;
  localparam int HI_W     = 16;
  localparam int KIND_W   = 3;
  localparam int QW_SHIFT = 4;
  localparam int QW_BYTES = 1 << QW_SHIFT;

  typedef enum logic [KIND_W-1:0] {
    K_REFE = 3'd0,
    K_CNT  = 3'd1,
    K_NEXT = 3'd2,
    K_REF  = 3'd3,
    K_REFS = 3'd4,
    K_CALL = 3'd5,
    K_RET  = 3'd6,
    K_END  = 3'd7
  } kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              irq;
    kind_e             kind;
    logic [QWC_W-1:0]  qwc;
  } tag_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_ADV
  } seq_state_e;
endpackage

// File: rtl/dcs_tag_decode.sv
module dcs_tag_decode
  import dcs_pkg::*;
(
  input  logic [ADDR_W-1:0] tag_ptr,
  input  tag_t              tag,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] resume_addr,
  output logic              stop,
  output logic              is_call,
  output logic              is_ret,
  output logic              addr_bad
);
  logic [ADDR_W-1:0] body;
  logic              uses_field;

  assign body        = tag_ptr + ADDR_W'(QW_BYTES);
  assign resume_addr = body + (ADDR_W'(tag.qwc) << QW_SHIFT);

  always_comb begin
    src_addr   = body;
    next_addr  = resume_addr;
    stop       = 1'b0;
    is_call    = 1'b0;
    is_ret     = 1'b0;
    uses_field = 1'b0;
    case (tag.kind)
      K_REFE: begin src_addr = tag.addr; stop = 1'b1; uses_field = 1'b1; end
      K_CNT:  begin end
      K_NEXT: begin next_addr = tag.addr; uses_field = 1'b1; end
      K_REF,
      K_REFS: begin src_addr = tag.addr; next_addr = body; uses_field = 1'b1; end
      K_CALL: begin next_addr = tag.addr; is_call = 1'b1; uses_field = 1'b1; end
      K_RET:  begin is_ret = 1'b1; end
      K_END:  begin stop = 1'b1; end
      default: stop = 1'b1;
    endcase
  end

  assign addr_bad = uses_field && (tag.addr[QW_SHIFT-1:0] != '0);
endmodule

// File: rtl/dcs_addr_stack.sv
module dcs_addr_stack #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 2,
  localparam int PW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] top_data,
  output logic [PW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] cnt;
  logic          do_push;
  logic          do_pop;

  assign full    = (cnt == PW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear && !push;

  always_ff @(posedge clk) begin
    if (do_push) store[cnt[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (do_push)  cnt <= cnt + 1'b1;
    else if (do_pop)   cnt <= cnt - 1'b1;
  end

  assign top_data = store[IW'(cnt - 1'b1)];
  assign count    = cnt;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter  int STACK_DEPTH = 2,
  localparam int SPW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_set,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              tie,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [63:0]       fetch_data,
  output logic              xfer_req,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [QWC_W-1:0]  xfer_qwc,
  input  logic              xfer_done,
  output logic              running,
  output logic [HI_W-1:0]   tag_hi,
  output logic [SPW-1:0]    stack_ptr,
  output logic              tag_irq,
  output logic              chain_done,
  output logic              chain_err
);
  seq_state_e        state;
  tag_t              tag_q;
  logic [ADDR_W-1:0] tag_ptr;
  logic [ADDR_W-1:0] nxt_q;
  logic              end_q;
  logic              irq_q;
  logic [ADDR_W-1:0] xaddr_q;
  logic [QWC_W-1:0]  xqwc_q;
  logic              run_q;
  logic              done_q;
  logic              irqp_q;
  logic              err_q;
  logic [HI_W-1:0]   hi_q;

  logic [ADDR_W-1:0] d_src, d_next, d_resume;
  logic              d_stop, d_call, d_ret, d_bad;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_full, stk_empty;
  logic              in_decode, tag_ok, accept_start;

  dcs_tag_decode u_dec (
    .tag_ptr     (tag_ptr),
    .tag         (tag_q),
    .src_addr    (d_src),
    .next_addr   (d_next),
    .resume_addr (d_resume),
    .stop        (d_stop),
    .is_call     (d_call),
    .is_ret      (d_ret),
    .addr_bad    (d_bad)
  );

  assign in_decode    = (state == S_DECODE);
  assign tag_ok       = !d_bad && !(d_call && stk_full);
  assign accept_start = (state == S_IDLE) && start_set &&
                        (start_addr[QW_SHIFT-1:0] == '0);

  dcs_addr_stack #(.DW(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept_start),
    .push      (in_decode && tag_ok && d_call),
    .pop       (in_decode && tag_ok && d_ret),
    .push_data (d_resume),
    .top_data  (stk_top),
    .count     (stack_ptr),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      tag_q   <= '0;
      tag_ptr <= '0;
      nxt_q   <= '0;
      end_q   <= 1'b0;
      irq_q   <= 1'b0;
      xaddr_q <= '0;
      xqwc_q  <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      irqp_q  <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= '0;
    end else begin
      done_q <= 1'b0;
      irqp_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_set) begin
            if (accept_start) begin
              err_q   <= 1'b0;
              run_q   <= 1'b1;
              tag_ptr <= start_addr;
              state   <= S_FETCH;
            end else begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end
          end
        end
        S_FETCH: begin
          if (fetch_ack) begin
            tag_q <= '{addr: fetch_data[63:32], irq: fetch_data[31],
                       kind: kind_e'(fetch_data[30:28]),
                       qwc: fetch_data[QWC_W-1:0]};
            hi_q  <= fetch_data[31:32-HI_W];
            state <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (!tag_ok) begin
            err_q  <= 1'b1;
            run_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            xaddr_q <= d_src;
            xqwc_q  <= tag_q.qwc;
            irq_q   <= tag_q.irq;
            if (d_ret) begin
              end_q <= stk_empty;
              nxt_q <= stk_top;
            end else begin
              end_q <= d_stop;
              nxt_q <= d_next;
            end
            state <= (tag_q.qwc != '0) ? S_XFER : S_ADV;
          end
        end
        S_XFER: begin
          if (xfer_done) state <= S_ADV;
        end
        S_ADV: begin
          if ((irq_q && tie) || end_q) begin
            irqp_q <= irq_q && tie;
            run_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            tag_ptr <= nxt_q;
            state   <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fetch_req  = (state == S_FETCH);
  assign fetch_addr = tag_ptr;
  assign xfer_req   = (state == S_XFER);
  assign xfer_addr  = xaddr_q;
  assign xfer_qwc   = xqwc_q;
  assign running    = run_q;
  assign tag_hi     = hi_q;
  assign tag_irq    = irqp_q;
  assign chain_done = done_q;
  assign chain_err  = err_q;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter  int STACK_DEPTH = 2,
  localparam int SPW         = $clog2(STACK_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           tie,
  input logic           fetch_req,
  input logic [31:0]    fetch_addr,
  input logic           fetch_ack,
  input logic           xfer_req,
  input logic [31:0]    xfer_addr,
  input logic [15:0]    xfer_qwc,
  input logic           xfer_done,
  input logic           running,
  input logic [SPW-1:0] stack_ptr,
  input logic           tag_irq,
  input logic           chain_done
);
  assert_req_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && xfer_req));

  assert_fetch_hold_R12: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  assert_xfer_hold_R12: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_qwc));

  assert_fetch_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> fetch_addr[3:0] == 4'h0);

  assert_xfer_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> xfer_addr[3:0] == 4'h0);

  assert_no_empty_xfer_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> xfer_qwc != 16'h0);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    chain_done |=> !chain_done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    chain_done |-> !running);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !running |-> !fetch_req && !xfer_req);

  assert_irq_needs_tie_R9: assert property (@(posedge clk) disable iff (rst)
    tag_irq |-> $past(tie));

  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    tag_irq |-> chain_done);

  assert_stack_bound_R6: assert property (@(posedge clk) disable iff (rst)
    stack_ptr <= SPW'(STACK_DEPTH));
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tie        (tie),
  .fetch_req  (fetch_req),
  .fetch_addr (fetch_addr),
  .fetch_ack  (fetch_ack),
  .xfer_req   (xfer_req),
  .xfer_addr  (xfer_addr),
  .xfer_qwc   (xfer_qwc),
  .xfer_done  (xfer_done),
  .running    (running),
  .stack_ptr  (stack_ptr),
  .tag_irq    (tag_irq),
  .chain_done (chain_done)
);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_set;
  logic [31:0] start_addr;
  logic        tie;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ack;
  logic [63:0] fetch_data;
  logic        xfer_req;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_qwc;
  logic        xfer_done;
  logic        running;
  logic [15:0] tag_hi;
  logic [1:0]  stack_ptr;
  logic        tag_irq;
  logic        chain_done;
  logic        chain_err;

  always #4 clk = ~clk;

  dma_chain_seq uut (.*);

  int checks = 0;
  int errors = 0;

  logic [63:0] mem [256];
  logic [31:0] got_f [16];
  logic [31:0] got_xa [16];
  logic [15:0] got_xq [16];
  logic [31:0] exp_f [16];
  logic [31:0] exp_xa [16];
  logic [15:0] exp_xq [16];
  int nf, nx, nef, nex;
  bit saw_irq, saw_done, injected;

  function automatic logic [63:0] mk(logic [31:0] a, logic irq, logic [2:0] kind,
                                     logic [1:0] pce, logic [15:0] q);
    return {a, irq, kind, pce, 10'd0, q};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [31:0] a, logic [63:0] t);
    mem[8'(a >> 4)] = t;
  endtask

  task automatic clear_all();
    foreach (mem[i]) mem[i] = '0;
    nef = 0;
    nex = 0;
  endtask

  task automatic ef(logic [31:0] a);
    exp_f[nef] = a;
    nef++;
  endtask

  task automatic ex(logic [31:0] a, logic [15:0] q);
    if (q != 0) begin   // R10: no command for a zero count
      exp_xa[nex] = a;
      exp_xq[nex] = q;
      nex++;
    end
  endtask

  task automatic run(logic [31:0] sa, bit inject);
    nf = 0; nx = 0; saw_irq = 0; saw_done = 0; injected = 0;
    @(negedge clk);
    start_addr = sa;
    start_set  = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      fetch_ack = 1'b0;
      xfer_done = 1'b0;
      start_set = 1'b0;
      if (chain_done) begin
        saw_done = 1;
        saw_irq  = tag_irq;
        break;
      end
      if (fetch_req) begin
        if (nf < 16) got_f[nf] = fetch_addr;
        nf++;
        fetch_data = mem[fetch_addr[11:4]];
        fetch_ack  = 1'b1;
      end
      if (xfer_req) begin
        if (nx < 16) begin got_xa[nx] = xfer_addr; got_xq[nx] = xfer_qwc; end
        nx++;
        xfer_done = 1'b1;
      end
      if (inject && nf == 1 && !injected) begin
        start_set  = 1'b1;
        start_addr = 32'h300;
        injected   = 1;
      end
      @(negedge clk);
    end
    fetch_ack = 1'b0;
    xfer_done = 1'b0;
    start_set = 1'b0;
    if (!saw_done) begin
      checks++;
      errors++;
      $display("FAIL R11 chain never finished: actual=running expected=done");
    end
  endtask

  task automatic compare(string req, bit exp_err, bit exp_irq);
    chk(req, "fetch count", nf, nef);
    for (int i = 0; i < nef && i < nf && i < 16; i++)
      chk(req, "fetch address", got_f[i], exp_f[i]);
    chk(req, "transfer count", nx, nex);
    for (int i = 0; i < nex && i < nx && i < 16; i++) begin
      chk(req, "transfer address", got_xa[i], exp_xa[i]);
      chk(req, "transfer qwc", 32'(got_xq[i]), 32'(exp_xq[i]));
    end
    chk("R11", "error flag", 32'(chain_err), 32'(exp_err));
    chk("R9", "irq pulse", 32'(saw_irq), 32'(exp_irq));
    chk("R11", "running after stop", 32'(running), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] t0, a, d, last;
    logic [15:0] q;
    string req;
    rst = 1'b1; start_set = 1'b0; start_addr = '0; tie = 1'b0;
    fetch_ack = 1'b0; fetch_data = '0; xfer_done = 1'b0;
    clear_all();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "running", 32'(running), 0);
    chk("R1", "fetch_req", 32'(fetch_req), 0);
    chk("R1", "xfer_req", 32'(xfer_req), 0);
    chk("R1", "stack_ptr", 32'(stack_ptr), 0);
    chk("R1", "chain_err", 32'(chain_err), 0);
    chk("R1", "chain_done", 32'(chain_done), 0);
    chk("R1", "tag_irq", 32'(tag_irq), 0);
    chk("R1", "tag_hi", 32'(tag_hi), 0);
    rst = 1'b0;
    @(negedge clk);

    // Sweep every tag kind with counts 0, 1, 3 (R2 R3 R4 R5 R6 R10)
    t0 = 32'h100; a = 32'h800; d = t0 + 16;
    for (int k = 0; k < 8; k++) begin
      for (int qi = 0; qi < 3; qi++) begin
        q = (qi == 0) ? 16'd0 : (qi == 1) ? 16'd1 : 16'd3;
        clear_all();
        put(t0, mk(a, 1'b0, 3'(k), 2'b11, q));
        last = mk(0, 1'b0, 3'd7, 2'b00, 16'd2);
        ef(t0);
        case (k)
          0: begin req = "R5"; ex(a, q); last = mk(a, 1'b0, 3'd0, 2'b11, q); end
          1: begin req = "R4"; put(d + 16*q, last); ef(d + 16*q);
                   ex(d, q); ex(d + 16*q + 16, 2); end
          2: begin req = "R4"; put(a, last); ef(a); ex(d, q); ex(a + 16, 2); end
          3, 4: begin req = "R5"; put(d, last); ef(d); ex(a, q); ex(d + 16, 2); end
          5: begin req = "R6"; put(a, mk(0, 1'b0, 3'd6, 2'b00, 16'd1));
                   put(d + 16*q, last); ef(a); ef(d + 16*q);
                   ex(d, q); ex(a + 16, 1); ex(d + 16*q + 16, 2); end
          6: begin req = "R6"; ex(d, q); last = mk(a, 1'b0, 3'd6, 2'b11, q); end
          default: begin req = "R4"; ex(d, q); last = mk(a, 1'b0, 3'd7, 2'b11, q); end
        endcase
        if (q == 0) req = {req, " R10"};
        run(t0, 1'b0);
        compare(req, 1'b0, 1'b0);
        chk("R2", "first fetch at start address", got_f[0], t0);
        chk("R6", "stack empty after chain", 32'(stack_ptr), 0);
        chk("R3", "tag_hi of last tag", 32'(tag_hi), 32'(last[31:16]));
      end
    end

    // R6 nested call and return, LIFO order
    clear_all();
    put(32'h100, mk(32'h400, 1'b0, 3'd5, 2'b00, 16'd1));
    put(32'h400, mk(32'h500, 1'b0, 3'd5, 2'b00, 16'd0));
    put(32'h500, mk(32'h0,   1'b0, 3'd6, 2'b00, 16'd1));
    put(32'h410, mk(32'h0,   1'b0, 3'd6, 2'b00, 16'd0));
    put(32'h120, mk(32'h0,   1'b0, 3'd7, 2'b00, 16'd0));
    ef(32'h100); ef(32'h400); ef(32'h500); ef(32'h410); ef(32'h120);
    ex(32'h110, 1); ex(32'h510, 1);
    run(32'h100, 1'b0);
    compare("R6", 1'b0, 1'b0);
    chk("R6", "stack empty after returns", 32'(stack_ptr), 0);

    // R7 third nested call overflows
    clear_all();
    put(32'h100, mk(32'h400, 1'b0, 3'd5, 2'b00, 16'd0));
    put(32'h400, mk(32'h500, 1'b0, 3'd5, 2'b00, 16'd0));
    put(32'h500, mk(32'h600, 1'b0, 3'd5, 2'b00, 16'd1));
    ef(32'h100); ef(32'h400); ef(32'h500);
    run(32'h100, 1'b0);
    compare("R7", 1'b1, 1'b0);
    chk("R7", "stack unchanged at overflow", 32'(stack_ptr), 2);

    // R8 misaligned address word under ref; R11 error cleared by new start
    clear_all();
    put(32'h100, mk(32'h804, 1'b0, 3'd3, 2'b00, 16'd2));
    ef(32'h100);
    run(32'h100, 1'b0);
    compare("R8", 1'b1, 1'b0);

    // R8 misaligned address word is ignored under cnt
    clear_all();
    put(32'h100, mk(32'h7, 1'b0, 3'd1, 2'b00, 16'd1));
    put(32'h120, mk(32'h0, 1'b0, 3'd7, 2'b00, 16'd0));
    ef(32'h100); ef(32'h120); ex(32'h110, 1);
    run(32'h100, 1'b0);
    compare("R8", 1'b0, 1'b0);

    // R8 misaligned start address
    clear_all();
    run(32'h108, 1'b0);
    compare("R8", 1'b1, 1'b0);
    chk("R11", "running stays low", 32'(running), 0);

    // R9 flagged tag with tie high ends early
    clear_all();
    put(32'h100, mk(32'h0, 1'b1, 3'd1, 2'b00, 16'd2));
    put(32'h130, mk(32'h0, 1'b0, 3'd7, 2'b10, 16'd1));
    tie = 1'b1;
    ef(32'h100); ex(32'h110, 2);
    run(32'h100, 1'b0);
    compare("R9", 1'b0, 1'b1);

    // R9 same chain with tie low: flag has no effect
    tie = 1'b0;
    nef = 0; nex = 0;
    ef(32'h100); ef(32'h130); ex(32'h110, 2); ex(32'h140, 1);
    run(32'h100, 1'b0);
    compare("R9", 1'b0, 1'b0);
    chk("R3", "tag_hi with priority bits", 32'(tag_hi), 32'h7800);

    // R2 start pulse during a running chain is ignored
    run(32'h100, 1'b1);
    compare("R2", 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule